// File: doc/BRIEF.md
# Numerically Controlled Cosine Oscillator

This block produces a stream of signed cosine samples, one per clock, at a frequency chosen by a signed tuning word. A phase register holds a fraction of one cycle. On every clock edge it adds a fixed base step of one sixteenth of a cycle, plus the tuning word scaled into the same fractional format. With a zero tuning word the output therefore repeats every 16 clocks. A 16 MHz clock gives a 1 MHz centre tone.

The upper bits of the phase address a full-cycle cosine table. The table is computed at elaboration from an integer series expansion, so it needs no external data. The table value is registered before it leaves the block. The block is meant to serve as the oscillator inside a digital phase-locked loop, where a loop filter supplies the tuning word.

Top module: `nco_cos_osc`

## Requirements
- R1: While `rst` is high the output holds the code 127, which is cos(0). Reset clears the phase. The first sample after release is therefore also 127, and the phase then advances from zero.
- R2: With `tune_i` = 0 the phase grows by exactly 4096/65536 (1/16 cycle) per clock. The output sequence repeats with a period of 16 samples.
- R3: The per-clock phase step is 4096 + 16·`tune_i` in units of 2^-16 cycle. `tune_i` is two's complement, so one tuning LSB is worth 2^-12 cycle. A positive word gives a step above 4096.
- R4: A negative `tune_i` gives a step below 4096, which lowers the frequency. At `tune_i` = -128 the step is 2048.
- R5: The phase is 16 bits of pure fraction and wraps modulo one cycle. No integer part is kept, so any long run of steps stays in range.
- R6: The table address is phase bits [15:6], the top 10 fractional bits. The six lower bits affect only later carries and never the current address.
- R7: Table entry x holds round(128·cos(2πx/1024)) as an 8-bit two's complement code. Rounding is half away from zero, and the value +128 is clipped to 127. Entry 512 holds -128.
- R8: The output sample seen after clock edge n is the table entry addressed by the phase that was present before edge n. This is a fixed latency of one register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tune_i | input | 8 | Signed tuning word added to the base phase step |
| cos_o | output | 8 | Signed cosine sample, registered |

## Verification
The hardest behaviour to reach from the ports is the phase fraction below the table address. With a zero or coarse tuning word, those six bits stay at zero and the address always lands on a multiple of 64. To exercise them, the stimulus uses small odd tuning words such as 1, 3 and -5, followed by a full sweep of every tuning value. Carries out of the hidden bits then change the address, and the scoreboard's exact phase model must track them sample by sample. Tuning words at the extremes drive many wraps of the phase. A reset in the middle of a run confirms that the phase restarts at cos(0).

// File: rtl/nco_pkg.sv
package nco_pkg;

  // pi scaled by 2^30, used by the integer series expansion
  localparam longint PI_Q30 = 64'sd3373259426;
  localparam longint ONE_Q30 = 64'sd1073741824;

  // cos(pi*q/(2*quarter)) for q in [0, quarter], result in Q30, never negative
  function automatic longint cos_quarter_q30(input int q, input int quarter);
    longint theta;
    longint theta_sq;
    longint term;
    longint acc;
    theta    = (longint'(q) * PI_Q30) / longint'(2 * quarter);
    theta_sq = (theta * theta) / ONE_Q30;
    term     = ONE_Q30;
    acc      = ONE_Q30;
    for (int k = 1; k <= 12; k++) begin
      term = -((term * theta_sq) / ONE_Q30) / longint'((2 * k - 1) * (2 * k));
      acc  = acc + term;
    end
    if (acc < 0) acc = 0;
    return acc;
  endfunction

  // rounded, clipped table code for entry idx of a 2^addr_w full-cycle table
  function automatic int cos_code(input int idx, input int addr_w, input int out_w);
    int     full;
    int     quarter;
    int     half;
    int     q;
    bit     neg;
    longint mag_q30;
    longint amp;
    longint mag;
    int     code;
    full    = 1 << addr_w;
    half    = full >> 1;
    quarter = full >> 2;
    if (idx <= quarter) begin
      q = idx; neg = 1'b0;
    end else if (idx < half) begin
      q = half - idx; neg = 1'b1;
    end else if (idx <= half + quarter) begin
      q = idx - half; neg = 1'b1;
    end else begin
      q = full - idx; neg = 1'b0;
    end
    amp     = longint'(1) << (out_w - 1);
    mag_q30 = cos_quarter_q30(q, quarter);
    mag     = (mag_q30 * amp + (ONE_Q30 >>> 1)) / ONE_Q30;
    code    = neg ? -int'(mag) : int'(mag);
    if (code > int'(amp) - 1) code = int'(amp) - 1;
    if (code < -int'(amp))    code = -int'(amp);
    return code;
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W      = 16,
  parameter int CTRL_W     = 8,
  parameter int CTRL_SHIFT = 4,
  parameter int BASE_INC   = 4096
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [CTRL_W-1:0] tune_i,
  output logic        [ACC_W-1:0]  phase_o,
  output logic        [ACC_W-1:0]  step_o
);

  localparam int EXT_W = ACC_W + 1;

  logic signed [EXT_W-1:0] tune_ext;
  logic signed [EXT_W-1:0] step_full;
  logic        [ACC_W-1:0] phase_q;

  // sign-extend and align the tuning word to the phase fraction
  assign tune_ext  = {{(EXT_W-CTRL_W){tune_i[CTRL_W-1]}}, tune_i};
  assign step_full = (tune_ext <<< CTRL_SHIFT) + EXT_W'(BASE_INC);
  assign step_o    = step_full[ACC_W-1:0];

  // fraction-only register: the carry out of the top bit is dropped
  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + step_o;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/nco_cos_rom.sv
module nco_cos_rom #(
  parameter int ADDR_W = 10,
  parameter int OUT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic        [ADDR_W-1:0] addr_i,
  output logic signed [OUT_W-1:0]  rd_o,
  output logic signed [OUT_W-1:0]  sample_o
);
  import nco_pkg::*;

  localparam int DEPTH    = 1 << ADDR_W;
  localparam int ZERO_CODE = cos_code(0, ADDR_W, OUT_W);

  logic signed [OUT_W-1:0] table_w [DEPTH];
  logic signed [OUT_W-1:0] sample_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam int CODE = cos_code(i, ADDR_W, OUT_W);
    assign table_w[i] = OUT_W'(CODE);
  end

  assign rd_o = table_w[addr_i];

  always_ff @(posedge clk) begin
    if (rst) sample_q <= OUT_W'(ZERO_CODE);
    else     sample_q <= rd_o;
  end

  assign sample_o = sample_q;

endmodule

// File: rtl/nco_cos_osc.sv
module nco_cos_osc #(
  parameter int CTRL_W      = 8,
  parameter int ACC_W       = 16,
  parameter int ADDR_W      = 10,
  parameter int OUT_W       = 8,
  parameter int CENTER_LOG2 = 4,
  parameter int CTRL_SHIFT  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [CTRL_W-1:0] tune_i,
  output logic signed [OUT_W-1:0]  cos_o
);

  localparam int BASE_INC = 1 << (ACC_W - CENTER_LOG2);

  logic        [ACC_W-1:0]  phase_acc;
  logic        [ACC_W-1:0]  phase_step;
  logic        [ADDR_W-1:0] rom_addr;
  logic signed [OUT_W-1:0]  rom_rd;

  nco_phase_acc #(
    .ACC_W      (ACC_W),
    .CTRL_W     (CTRL_W),
    .CTRL_SHIFT (CTRL_SHIFT),
    .BASE_INC   (BASE_INC)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .tune_i  (tune_i),
    .phase_o (phase_acc),
    .step_o  (phase_step)
  );

  // top fractional bits select the table entry
  assign rom_addr = phase_acc[ACC_W-1 -: ADDR_W];

  nco_cos_rom #(
    .ADDR_W (ADDR_W),
    .OUT_W  (OUT_W)
  ) u_rom (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (rom_addr),
    .rd_o     (rom_rd),
    .sample_o (cos_o)
  );

endmodule

// File: rtl/nco_cos_osc_chk.sv
module nco_cos_osc_chk #(
  parameter int CTRL_W      = 8,
  parameter int ACC_W       = 16,
  parameter int OUT_W       = 8,
  parameter int CENTER_LOG2 = 4,
  parameter int CTRL_SHIFT  = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic signed [CTRL_W-1:0] tune_i,
  input logic        [ACC_W-1:0]  acc,
  input logic        [ACC_W-1:0]  step,
  input logic signed [OUT_W-1:0]  rd_data,
  input logic signed [OUT_W-1:0]  cos_o
);

  localparam int BASE = 1 << (ACC_W - CENTER_LOG2);
  localparam int TOP  = (1 << (OUT_W - 1)) - 1;

  int               exp_inc;
  logic [ACC_W-1:0] exp_next;

  always_comb begin
    exp_inc  = BASE + int'(tune_i) * (1 << CTRL_SHIFT);
    exp_next = acc + ACC_W'(exp_inc);
  end

  // R1: first sample after release is cos(0)
  a_r1_release_cos0: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (int'(cos_o) == TOP));

  // R3: phase advances by base plus scaled tuning word
  a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (acc == $past(exp_next)));

  // R3: positive word steps faster than centre
  a_r3_pos_faster: assert property (@(posedge clk) disable iff (rst)
    (tune_i > 0) |-> (int'(step) > BASE));

  // R4: negative word steps slower than centre
  a_r4_neg_slower: assert property (@(posedge clk) disable iff (rst)
    (tune_i < 0) |-> (int'(step) < BASE));

  // R7: zero phase yields the clipped top code one cycle later
  a_r7_clip_top: assert property (@(posedge clk) disable iff (rst)
    (acc == '0) |=> (int'(cos_o) == TOP));

  // R8: output is last cycle's table read
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cos_o == $past(rd_data)));

endmodule

bind nco_cos_osc nco_cos_osc_chk #(
  .CTRL_W      (CTRL_W),
  .ACC_W       (ACC_W),
  .OUT_W       (OUT_W),
  .CENTER_LOG2 (CENTER_LOG2),
  .CTRL_SHIFT  (CTRL_SHIFT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tune_i  (tune_i),
  .acc     (phase_acc),
  .step    (phase_step),
  .rd_data (rom_rd),
  .cos_o   (cos_o)
);

// File: tb/nco_cos_osc_tb.sv
module nco_cos_osc_tb;

  localparam real PI_R = 3.14159265358979323846;

  typedef struct {
    int    exp;
    string tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [7:0] tune_i = '0;
  logic signed [7:0] cos_o;

  item_t q[$];
  int    checks   = 0;
  int    failures = 0;
  int    phase_ref = 0;

  always #2.5 clk = ~clk;

  nco_cos_osc u_dut (
    .clk    (clk),
    .rst    (rst),
    .tune_i (tune_i),
    .cos_o  (cos_o)
  );

  // expected table code from a real-valued cosine (R7)
  function automatic int ref_code(input int a);
    real r;
    int  v;
    r = $cos(2.0 * PI_R * real'(a) / 1024.0) * 128.0;
    if (r >= 0.0) v = $rtoi(r + 0.5);
    else          v = -$rtoi(-r + 0.5);
    if (v > 127) v = 127;
    return v;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  // driver: called at a falling edge; applies word, predicts next sample (R8, R6)
  task automatic drive(input int t, input string tag);
    item_t it;
    tune_i    = 8'(t);
    it.exp    = ref_code(phase_ref / 64);
    it.tag    = tag;
    q.push_back(it);
    phase_ref = (phase_ref + 4096 + 16 * t) % 65536;
    if (phase_ref < 0) phase_ref += 65536;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst    = 1'b1;
    tune_i = '0;
    repeat (3) @(negedge clk);
    check("R1 output during reset", int'(cos_o), 127);
    phase_ref = 0;
    rst = 1'b0;
  endtask

  // monitor: away from edges, compare against the scoreboard
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, int'(cos_o), it.exp);
      end
    end
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired got=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1, R7: first sample is cos(0) clipped to 127
    drive(0, "R1 first sample");
    // R2: centre frequency, period 16; includes entry 512 = -128 (R7)
    for (int i = 0; i < 40; i++) drive(0, "R2 zero word");
    // R3: positive word
    for (int i = 0; i < 60; i++) drive(64, "R3 positive word");
    // R4: negative word
    for (int i = 0; i < 60; i++) drive(-64, "R4 negative word");
    // R5: extremes, many wraps
    for (int i = 0; i < 40; i++) drive(127, "R5 max word wrap");
    for (int i = 0; i < 40; i++) drive(-128, "R5 min word wrap");
    // R6: small odd words exercise bits below the address
    for (int i = 0; i < 60; i++) drive((i % 3 == 0) ? 1 : ((i % 3 == 1) ? 3 : -5), "R6 sub-address carry");
    // R5, R6: full sweep of tuning values
    for (int i = -128; i < 128; i++) drive(i, "R5 sweep");
    // R1: reset mid-run restarts at cos(0)
    do_reset();
    drive(0, "R1 restart first sample");
    for (int i = 0; i < 32; i++) drive(0, "R7 table after restart");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule